// File: doc/BRIEF.md
# Cycle Counter Monitor Unit

This unit keeps a 64-bit count of core clock cycles and exposes it, together with the registers that control it, through a small register port. Each access carries a 3-bit word address, 32-bit write data, a write strobe, a read strobe and a privilege flag. Counting needs two enables at once. One is a global enable in the control register. The other is a counter enable that is switched on and off through separate write-one-to-set and write-one-to-clear registers. The control register also selects:

- a divide-by-64 prescaler;
- the overflow point, either a wrap of the low 32 bits or of all 64 bits;
- a stop input that halts counting while monitoring is prohibited;
- freezing the counter once it has overflowed.

Privileged accesses always proceed. Unprivileged accesses are filtered by a 4-bit user-enable register. A refused write is dropped silently. A refused read returns zero and raises an error flag. Reads are answered by a three-state access machine.

- **IDLE**: no response is pending.
- **DATA**: a permitted read is being returned.
- **DENY**: a refused read is being answered with zero.

On every clock edge the next state is chosen from the read strobe alone. A read strobe moves the machine to DATA (*grant*) or to DENY (*refuse*), and no read strobe returns it to IDLE (*retire*). This holds from any state, so reads may be issued back to back.

Top module: `cyc_mon_unit`

Word addresses:

| Address | Register |
|---|---|
| 0 | control |
| 1 | enable-set |
| 2 | enable-clear |
| 3 | overflow status |
| 4 | software increment |
| 5 | user enable |
| 6 | counter low word |
| 7 | counter high word |

## Requirements
- R1: After reset the control register reads 0x41093000, and enable-set, enable-clear, overflow status, user enable and both counter words read 0. Control bits 31:11 are constant, and address 4 always reads 0.
- R2: The counter advances by one on each clock edge at which control bit 0 and counter-enable bit 31 are both 1 and control bit 3 is 0. Otherwise it holds.
- R3: Writing 1 to bit 31 at address 1 sets the counter enable, and writing 1 to bit 31 at address 2 clears it. A write of 0 to bit 31 of either register changes nothing. Both addresses read the enable state in bit 31, with all other bits 0.
- R4: With control bit 3 at 1, the counter advances once for every 64 edges at which counting is enabled. The count is measured from the last counter reset.
- R5: Overflow sets bit 31 of the overflow status register. With control bit 6 at 0, overflow occurs when the low 32 bits wrap. With bit 6 at 1, it occurs only when all 64 bits wrap. The count itself always carries across the full 64 bits.
- R6: Writing 1 to bit 31 of the overflow status register clears the flag, and writing 0 leaves it unchanged.
- R7: With control bit 5 at 1, the counter holds while the input cnt_prohibit is 1. With bit 5 at 0, cnt_prohibit has no effect.
- R8: With control bit 9 at 1, the counter holds while the overflow flag is set.
- R9: Writing control bit 2 as 1 zeroes the counter and the prescaler. Bit 2 always reads back 0.
- R10: An unprivileged write that no user-enable bit permits changes nothing. A refused unprivileged read returns reg_rvalid with data 0 and reg_err at 1. A privileged access is never refused.
- R11: User-enable bit 0 permits unprivileged access to every register except writes to the user-enable register. Bit 1 permits unprivileged writes to address 4. Bit 2 permits unprivileged reads of addresses 6 and 7.
- R12: The read response (reg_rvalid with data) appears in the cycle after the edge that sampled reg_rd. It holds the register value as it was at that edge.
- R13: Writing address 6 or address 7 replaces the low or high counter word. Such a write takes priority over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_priv | input | 1 | 1 when the access is privileged |
| cnt_prohibit | input | 1 | Monitoring-prohibited condition |
| reg_rvalid | output | 1 | Read response valid |
| reg_rdata | output | 32 | Read response data |
| reg_err | output | 1 | Refused read |

## Verification
The assertions take for granted that reg_rd and reg_wr are never high in the same cycle, and that every strobe is 0 while reset is held. They also assume the counter is only loaded through the register port, so any change of count while the run gate is low must come from a load. The stimulus issues one access per cycle through tasks that drive exactly one strobe. It changes cnt_prohibit only between accesses, and it sweeps every user-enable value against every address with unprivileged reads.

// File: rtl/cyc_mon_pkg.sv
package cyc_mon_pkg;

    localparam int unsigned REG_DW = 32;
    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 3'd0,
        RA_CEN_SET = 3'd1,
        RA_CEN_CLR = 3'd2,
        RA_OVF     = 3'd3,
        RA_SWINC   = 3'd4,
        RA_USER    = 3'd5,
        RA_CNT_LO  = 3'd6,
        RA_CNT_HI  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        AX_IDLE = 2'd0,
        AX_DATA = 2'd1,
        AX_DENY = 2'd2
    } acc_state_e;

    // writable control fields
    typedef struct packed {
        logic frz;   // bit 9
        logic lc;    // bit 6
        logic dp;    // bit 5
        logic div;   // bit 3
        logic en;    // bit 0
    } ctl_t;

    localparam int unsigned CTL_RO_LSB = 11;
    localparam int unsigned FLAG_BIT   = 31;

endpackage

// File: rtl/cyc_mon_regs.sv
module cyc_mon_regs
    import cyc_mon_pkg::*;
#(
    parameter logic [REG_DW-1:0] CTL_RESET = 32'h4109_3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [REG_AW-1:0] addr,
    input  ctl_t              w_ctl,
    input  logic              w_rst,
    input  logic              w_b31,
    input  logic [3:0]        w_user,
    output ctl_t              ctl_q,
    output logic              cen_q,
    output logic [3:0]        user_q,
    output logic [REG_DW-1:0] ctl_word,
    output logic              cnt_clear,
    output logic              load_lo,
    output logic              load_hi,
    output logic              ovf_clr
);

    localparam logic [REG_DW-1:0] RO_MASK = ~((32'd1 << CTL_RO_LSB) - 32'd1);

    logic wr_ctl, wr_set, wr_clr, wr_user;

    always_comb begin
        wr_ctl  = wr_ok && (addr == RA_CTRL);
        wr_set  = wr_ok && (addr == RA_CEN_SET);
        wr_clr  = wr_ok && (addr == RA_CEN_CLR);
        wr_user = wr_ok && (addr == RA_USER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            cen_q  <= 1'b0;
            user_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= w_ctl;
            if (wr_set && w_b31) cen_q <= 1'b1;
            else if (wr_clr && w_b31) cen_q <= 1'b0;
            if (wr_user) user_q <= w_user;
        end
    end

    always_comb begin
        ctl_word    = CTL_RESET & RO_MASK;
        ctl_word[9] = ctl_q.frz;
        ctl_word[6] = ctl_q.lc;
        ctl_word[5] = ctl_q.dp;
        ctl_word[3] = ctl_q.div;
        ctl_word[0] = ctl_q.en;
        cnt_clear   = wr_ctl && w_rst;
        load_lo     = wr_ok && (addr == RA_CNT_LO);
        load_hi     = wr_ok && (addr == RA_CNT_HI);
        ovf_clr     = wr_ok && (addr == RA_OVF) && w_b31;
    end

endmodule

// File: rtl/cyc_mon_counter.sv
module cyc_mon_counter
    import cyc_mon_pkg::*;
#(
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned DIV_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic              cen,
    input  logic              prohibit,
    input  logic              cnt_clear,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              ovf_clr,
    input  logic [REG_DW-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              run
);

    localparam int unsigned HALF = CNT_W / 2;
    localparam int unsigned PW   = (DIV_LOG2 > 0) ? DIV_LOG2 : 1;

    logic [PW-1:0] presc;
    logic          presc_full;
    logic          tick;
    logic          wrap_evt;

    always_comb begin
        run = ctl.en && cen && !(ctl.dp && prohibit) && !(ctl.frz && ovf);
    end

    generate
        if (DIV_LOG2 > 0) begin : g_presc
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              presc <= '0;
                else if (cnt_clear)      presc <= '0;
                else if (run && ctl.div) presc <= presc + 1'b1;
            end
            assign presc_full = &presc;
        end else begin : g_nopresc
            assign presc      = '0;
            assign presc_full = 1'b1;
        end
    endgenerate

    always_comb begin
        tick     = run && (!ctl.div || presc_full);
        wrap_evt = tick && (ctl.lc ? (&count) : (&count[HALF-1:0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_clear) begin
            count <= '0;
        end else if (load_lo || load_hi) begin
            if (load_lo) count[HALF-1:0]     <= wdata[HALF-1:0];
            if (load_hi) count[CNT_W-1:HALF] <= wdata[HALF-1:0];
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf <= 1'b0;
        else if (wrap_evt) ovf <= 1'b1;
        else if (ovf_clr)  ovf <= 1'b0;
    end

endmodule

// File: rtl/cyc_mon_access.sv
module cyc_mon_access
    import cyc_mon_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_priv,
    input  logic [REG_AW-1:0] addr,
    input  logic [3:0]        user,
    input  logic [REG_DW-1:0] ctl_word,
    input  logic              cen,
    input  logic              ovf,
    input  logic [CNT_W-1:0]  count,
    output logic              wr_ok,
    output logic              rvalid,
    output logic [REG_DW-1:0] rdata,
    output logic              err
);

    acc_state_e        state, nxt;
    logic              rd_ok;
    logic              cnt_addr;
    logic [REG_DW-1:0] mux;
    logic [REG_DW-1:0] data_q;

    always_comb begin
        cnt_addr = (addr == RA_CNT_LO) || (addr == RA_CNT_HI);
        rd_ok    = reg_priv || user[0] || (user[2] && cnt_addr);
        wr_ok    = reg_wr && (reg_priv
                   || (user[0] && addr != RA_USER)
                   || (user[1] && addr == RA_SWINC));
    end

    always_comb begin
        mux = '0;
        unique case (addr)
            RA_CTRL:    mux = ctl_word;
            RA_CEN_SET: mux[FLAG_BIT] = cen;
            RA_CEN_CLR: mux[FLAG_BIT] = cen;
            RA_OVF:     mux[FLAG_BIT] = ovf;
            RA_SWINC:   mux = '0;
            RA_USER:    mux[3:0] = user;
            RA_CNT_LO:  mux = count[REG_DW-1:0];
            RA_CNT_HI:  mux = count[CNT_W-1:CNT_W-REG_DW];
            default:    mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= AX_IDLE;
            data_q <= '0;
        end else begin
            state <= nxt;
            if (reg_rd) data_q <= rd_ok ? mux : '0;
        end
    end

    // transitions: grant, refuse, retire
    always_comb begin
        nxt = AX_IDLE;
        unique case (state)
            AX_IDLE, AX_DATA, AX_DENY: begin
                if (reg_rd) nxt = rd_ok ? AX_DATA : AX_DENY;
                else        nxt = AX_IDLE;
            end
            default: nxt = AX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        rdata  = '0;
        unique case (state)
            AX_IDLE: ;
            AX_DATA: begin
                rvalid = 1'b1;
                rdata  = data_q;
            end
            AX_DENY: begin
                rvalid = 1'b1;
                err    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cyc_mon_unit.sv
module cyc_mon_unit
    import cyc_mon_pkg::*;
#(
    parameter int unsigned      CNT_W     = 64,
    parameter int unsigned      DIV_LOG2  = 6,
    parameter logic [31:0]      CTL_RESET = 32'h4109_3000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_priv,
    input  logic        cnt_prohibit,
    output logic        reg_rvalid,
    output logic [31:0] reg_rdata,
    output logic        reg_err
);

    ctl_t              ctl_q;
    ctl_t              w_ctl;
    logic              cen_q;
    logic [3:0]        user_q;
    logic [REG_DW-1:0] ctl_word;
    logic              cnt_clear, load_lo, load_hi, ovf_clr, wr_ok;
    logic              cnt_load;
    logic [CNT_W-1:0]  count;
    logic              ovf;
    logic              run;

    always_comb begin
        w_ctl.frz = reg_wdata[9];
        w_ctl.lc  = reg_wdata[6];
        w_ctl.dp  = reg_wdata[5];
        w_ctl.div = reg_wdata[3];
        w_ctl.en  = reg_wdata[0];
        cnt_load  = cnt_clear || load_lo || load_hi;
    end

    cyc_mon_regs #(.CTL_RESET(CTL_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .addr      (reg_addr),
        .w_ctl     (w_ctl),
        .w_rst     (reg_wdata[2]),
        .w_b31     (reg_wdata[FLAG_BIT]),
        .w_user    (reg_wdata[3:0]),
        .ctl_q     (ctl_q),
        .cen_q     (cen_q),
        .user_q    (user_q),
        .ctl_word  (ctl_word),
        .cnt_clear (cnt_clear),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .ovf_clr   (ovf_clr)
    );

    cyc_mon_counter #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl_q),
        .cen       (cen_q),
        .prohibit  (cnt_prohibit),
        .cnt_clear (cnt_clear),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .ovf_clr   (ovf_clr),
        .wdata     (reg_wdata),
        .count     (count),
        .ovf       (ovf),
        .run       (run)
    );

    cyc_mon_access #(.CNT_W(CNT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_priv (reg_priv),
        .addr     (reg_addr),
        .user     (user_q),
        .ctl_word (ctl_word),
        .cen      (cen_q),
        .ovf      (ovf),
        .count    (count),
        .wr_ok    (wr_ok),
        .rvalid   (reg_rvalid),
        .rdata    (reg_rdata),
        .err      (reg_err)
    );

endmodule

// File: rtl/cyc_mon_unit_sva.sv
module cyc_mon_unit_sva
    import cyc_mon_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic             reg_priv,
    input logic             reg_rvalid,
    input logic [31:0]      reg_rdata,
    input logic             reg_err,
    input logic [CNT_W-1:0] count,
    input logic             run,
    input logic             load,
    input logic             ovf,
    input ctl_t             ctl
);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !ctl.div) |=> (count == $past(count) + 1'b1));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.frz && ovf && !load) |=> $stable(count));

    p_ovf_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(count[31:0]) == 32'hFFFF_FFFF));

    p_deny_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rvalid && reg_rdata == 32'd0));

    p_priv_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_priv) |=> !reg_err);

    p_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_rd));

endmodule

bind cyc_mon_unit cyc_mon_unit_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_priv   (reg_priv),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .reg_err    (reg_err),
    .count      (count),
    .run        (run),
    .load       (cnt_load),
    .ovf        (ovf),
    .ctl        (ctl_q)
);

// File: tb/cyc_mon_unit_bench.sv
module cyc_mon_unit_bench;

    localparam logic [2:0] A_CTL = 3'd0, A_SET = 3'd1, A_CLR = 3'd2, A_OVF = 3'd3,
                           A_SWI = 3'd4, A_USR = 3'd5, A_LO = 3'd6, A_HI = 3'd7;
    localparam logic [31:0] CTL_RST = 32'h4109_3000;
    localparam logic [31:0] B31 = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_priv = 1'b1, cnt_prohibit = 1'b0;
    logic        reg_rvalid, reg_err;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cyc_mon_unit u_cyc_mon_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_priv(reg_priv),
        .cnt_prohibit(cnt_prohibit), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .reg_err(reg_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic p);
        reg_addr = a; reg_wdata = d; reg_priv = p; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_priv = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, input logic p, output logic [31:0] d,
                      output logic e, output logic v);
        reg_addr = a; reg_priv = p; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; reg_priv = 1'b1;
        d = reg_rdata; e = reg_err; v = reg_rvalid;
    endtask

    function automatic logic [31:0] rdp(input logic [2:0] a);
        return 32'd0;
    endfunction

    // m edges of counting with the given control bits
    task automatic run_cyc(input logic [31:0] bits, input int m, input bit clr, input bit en);
        wr(A_CTL, bits | (en ? 32'd1 : 32'd0) | (clr ? 32'd4 : 32'd0), 1'b1);
        repeat (m - 1) @(negedge clk);
        wr(A_CTL, bits, 1'b1);
    endtask

    task automatic preset(input logic [31:0] hi, input logic [31:0] lo);
        wr(A_LO, lo, 1'b1);
        wr(A_HI, hi, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic e, v;
        int m_list [6] = '{1, 63, 64, 65, 128, 200};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CTL, 1, d, e, v); chk("R1 ctl", d, CTL_RST);
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), 1, d, e, v); chk("R1 zero reg", d, 32'd0);
        end

        // R12 response timing and valid
        wr(A_LO, 32'h1234_5678, 1);
        rd(A_LO, 1, d, e, v);
        chk("R12 rvalid", {31'd0, v}, 32'd1);
        chk("R13 load low", d, 32'h1234_5678);
        chk("R12 no err", {31'd0, e}, 32'd0);
        @(negedge clk);
        chk("R12 rvalid drops", {31'd0, reg_rvalid}, 32'd0);

        // R3 set/clear
        wr(A_SET, 32'h7FFF_FFFF, 1); rd(A_SET, 1, d, e, v); chk("R3 set zero-bit", d, 32'd0);
        wr(A_SET, B31, 1);
        rd(A_SET, 1, d, e, v); chk("R3 set reads", d, B31);
        rd(A_CLR, 1, d, e, v); chk("R3 clr reads", d, B31);
        wr(A_CLR, 32'h7FFF_FFFF, 1); rd(A_CLR, 1, d, e, v); chk("R3 clr zero-bit", d, B31);
        wr(A_CLR, B31, 1); rd(A_SET, 1, d, e, v); chk("R3 cleared", d, 32'd0);

        // R2 gate sweep
        for (int g = 0; g < 4; g++) begin
            if (g[1]) wr(A_SET, B31, 1); else wr(A_CLR, B31, 1);
            run_cyc(32'd0, 10 + g, 1'b1, g[0]);
            rd(A_LO, 1, d, e, v);
            chk("R2 gated count", d, (g == 3) ? 32'(10 + g) : 32'd0);
            rd(A_HI, 1, d, e, v); chk("R2 high word", d, 32'd0);
        end

        // R9 reset bit reads 0 and zeroes
        wr(A_CTL, 32'h4, 1);
        rd(A_CTL, 1, d, e, v); chk("R9 bit2 reads 0", d, CTL_RST);
        rd(A_LO, 1, d, e, v); chk("R9 counter zeroed", d, 32'd0);

        // R4 divider sweep
        foreach (m_list[i]) begin
            run_cyc(32'h8, m_list[i], 1'b1, 1'b1);
            rd(A_LO, 1, d, e, v); chk("R4 divided count", d, 32'(m_list[i] / 64));
        end

        // R7 prohibit
        cnt_prohibit = 1'b1;
        run_cyc(32'h20, 10, 1'b1, 1'b1);
        rd(A_LO, 1, d, e, v); chk("R7 held", d, 32'd0);
        run_cyc(32'h0, 11, 1'b1, 1'b1);
        rd(A_LO, 1, d, e, v); chk("R7 ignored", d, 32'd11);
        cnt_prohibit = 1'b0;

        // R5 low-word overflow
        preset(32'd5, 32'hFFFF_FFFE);
        run_cyc(32'h0, 2, 1'b0, 1'b1);
        rd(A_LO, 1, d, e, v); chk("R5 lo wrap", d, 32'd0);
        rd(A_HI, 1, d, e, v); chk("R5 carry", d, 32'd6);
        rd(A_OVF, 1, d, e, v); chk("R5 flag lc0", d, B31);
        wr(A_OVF, 32'd0, 1); rd(A_OVF, 1, d, e, v); chk("R6 zero keeps", d, B31);
        wr(A_OVF, B31, 1); rd(A_OVF, 1, d, e, v); chk("R6 cleared", d, 32'd0);

        // R5 long mode
        preset(32'd5, 32'hFFFF_FFFE);
        run_cyc(32'h40, 2, 1'b0, 1'b1);
        rd(A_OVF, 1, d, e, v); chk("R5 no flag lc1", d, 32'd0);
        preset(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_cyc(32'h40, 1, 1'b0, 1'b1);
        rd(A_HI, 1, d, e, v); chk("R5 full wrap", d, 32'd0);
        rd(A_OVF, 1, d, e, v); chk("R5 flag lc1", d, B31);
        wr(A_OVF, B31, 1);

        // R8 freeze
        preset(32'd0, 32'hFFFF_FFFE);
        run_cyc(32'h200, 6, 1'b0, 1'b1);
        rd(A_LO, 1, d, e, v); chk("R8 frozen", d, 32'd0);
        rd(A_HI, 1, d, e, v); chk("R8 frozen hi", d, 32'd1);
        wr(A_OVF, B31, 1);
        preset(32'd0, 32'hFFFF_FFFE);
        run_cyc(32'h0, 6, 1'b0, 1'b1);
        rd(A_LO, 1, d, e, v); chk("R8 not frozen", d, 32'd4);
        wr(A_OVF, B31, 1);

        // R10 refused write
        wr(A_USR, 32'd0, 1);
        wr(A_CTL, 32'h1, 0);
        rd(A_CTL, 1, d, e, v); chk("R10 write dropped", d, CTL_RST);
        // R11 user reg write needs privilege
        wr(A_USR, 32'h1, 1);
        wr(A_USR, 32'hF, 0);
        rd(A_USR, 1, d, e, v); chk("R11 user reg kept", d, 32'h1);
        wr(A_LO, 32'h55, 0);
        rd(A_LO, 1, d, e, v); chk("R11 bit0 write", d, 32'h55);

        // R10/R11 sweep of user bits against addresses
        for (int u = 0; u < 16; u++) begin
            wr(A_USR, 32'(u), 1);
            for (int a = 0; a < 8; a++) begin
                bit ok;
                ok = u[0] || (u[2] && a >= 6);
                rd(3'(a), 0, d, e, v);
                chk("R11 err sweep", {31'd0, e}, {31'd0, !ok});
                if (!ok) chk("R10 denied data", d, 32'd0);
                chk("R10 rvalid", {31'd0, v}, 32'd1);
            end
        end
        wr(A_USR, 32'd0, 1);
        rd(A_LO, 1, d, e, v); chk("R10 privileged read", {31'd0, e}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule